// File: doc/BRIEF.md
# ADC Continuous-Read Serial Output Port

This block is the device-side serial data port of a converter that streams results without a read command. A conversion engine hands it a 24-bit result with a one-cycle strobe. The port then runs a fixed update window of master-clock cycles. At the end of that window it loads the result into its output frame and pulls the active-low ready line low. A host with chip select low clocks the result out on the serial clock, MSB first. The frame can carry an optional trailing checksum byte. If the host keeps clocking past the frame, the same result is sent again from its most significant bit.

The ready line behaves in one of two ways, chosen by a mode input. In gate mode, the first serial-clock falling edge of a read clears it. In pulse mode, it stays asserted until the next result's update window opens. While no bits are being shifted, the data output mirrors the ready line. The host leaves the data input low. To leave continuous mode, it shifts in a single stop byte; after that the port no longer streams data. The serial clock, chip select and data input are sampled on the master clock and are assumed to be synchronous to it, with every level held for at least two master-clock cycles.

Top module: `adc_rdc_port`

## Requirements
- R1: After reset, `drdy_n` is 1 and `rdc_active` is 1. While `cs_n` is high, `dout_oe` is 0; with `cs_n` low and no bits shifted yet, `dout` equals `drdy_n`.
- R2: `drdy_n` goes to 1 at the clock edge that samples `res_valid` high, and falls to 0 exactly UPD_CYCLES (default 20) clock edges after that edge.
- R3: While the update window is open (from the strobe edge until `drdy_n` falls), `dout` is held at 0.
- R4: Between frames (no rising serial edge since the last load or since chip select went low) and outside the window, `dout` equals `drdy_n`; after a load with `cs_n` low, it is therefore 0.
- R5: Each serial-clock rising edge with `cs_n` low presents the next frame bit on `dout`, one clock edge later. The bits go MSB first, in the byte order `res_data[23:16]`, `[15:8]`, `[7:0]`.
- R6: With `cksum_en` = 1, a fourth byte follows the data. It equals (`res_data[23:16]` + `res_data[15:8]` + `res_data[7:0]` + 0x9B) mod 256.
- R7: After the last bit of the frame (bit 24 without checksum, bit 32 with it), the next rising edge restarts the same result from its MSB.
- R8: In gate mode (`mode_pulse` = 0), the first serial-clock falling edge with `cs_n` low after `drdy_n` fell returns `drdy_n` to 1.
- R9: In pulse mode (`mode_pulse` = 1), serial-clock activity does not change `drdy_n`. It stays 0 until the next strobe.
- R10: Raising `cs_n` restarts the bit position, so the next read begins at the MSB.
- R11: Bits on `din` are sampled on serial-clock falling edges and grouped into bytes, MSB first, counted from the moment `cs_n` goes low. A byte equal to 0x11 clears `rdc_active` until reset. After that, rising edges shift out nothing, and `dout` equals `drdy_n`.
- R12: A `din` byte other than 0x11 leaves `rdc_active` at 1 and does not disturb the data stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: new conversion result |
| res_data | input | 24 | Conversion result |
| mode_pulse | input | 1 | 1 = pulse mode, 0 = gate mode |
| cksum_en | input | 1 | Append checksum byte to the frame |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input |
| drdy_n | output | 1 | Active-low data-ready |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Output enable for dout (high while selected) |
| rdc_active | output | 1 | Continuous-read mode is active |

## Verification
A wrong window counter shows up as a ready fall one or more edges off the 20-edge mark, so it is caught on the very first result. A bit counter that is off, or that does not wrap, corrupts the first byte read or the repeated MSB after 24 or 32 edges. A bad stop decoder shows up within eight serial falling edges: either a non-stop byte ends the mode, or 0x11 fails to end it. A misplaced output-select term appears as a 1 on `dout` during the window, or as stale data between frames.

// File: rtl/adc_rdc_pkg.sv
// Package: shared constants and the frame checksum function.
// Assumes: data width is a whole number of bytes.
package adc_rdc_pkg;

    localparam logic [7:0] STOP_OPCODE = 8'h11;
    localparam logic [7:0] CKSUM_SEED  = 8'h9B;

    // Sum every byte of a result plus the seed, modulo 256.
    function automatic logic [7:0] frame_cksum(input logic [23:0] d);
        logic [7:0] acc;
        acc = CKSUM_SEED;
        for (int i = 0; i < 3; i++) begin
            acc = acc + d[i*8 +: 8];
        end
        return acc;
    endfunction

endpackage

// File: rtl/adc_rdc_upd_win.sv
// Update window and ready line.
// A strobe opens a window of UPD_CYCLES edges, raises the ready line and
// captures the result. The last window edge pulses load and lowers the ready line.
// In gate mode, a qualified serial falling edge raises the ready line again.
// Assumes: UPD_CYCLES >= 1.
module adc_rdc_upd_win #(
    parameter int DATA_W     = 24,
    parameter int UPD_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              mode_pulse,
    input  logic              sclk_fall,
    output logic              drdy_n,
    output logic              busy,
    output logic              load,
    output logic [DATA_W-1:0] data_q
);
    localparam int CW = $clog2(UPD_CYCLES + 1);
    localparam logic [CW-1:0] WIN_INIT = CW'(UPD_CYCLES);
    localparam logic [CW-1:0] WIN_LAST = CW'(1);

    logic [CW-1:0] win_cnt;

    assign busy = (win_cnt != '0);
    assign load = (win_cnt == WIN_LAST) && !res_valid;

    // Window countdown, result capture and ready-line control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            drdy_n  <= 1'b1;
            data_q  <= '0;
        end else if (res_valid) begin
            data_q  <= res_data;
            win_cnt <= WIN_INIT;
            drdy_n  <= 1'b1;
        end else if (busy) begin
            win_cnt <= win_cnt - 1'b1;
            if (win_cnt == WIN_LAST) begin
                drdy_n <= 1'b0;
            end
        end else if (sclk_fall && !mode_pulse) begin
            drdy_n <= 1'b1;
        end
    end

    AST_READY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> $past(busy)); // R2

    AST_PULSE_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drdy_n) && $past(mode_pulse)) |-> $past(res_valid)); // R9

endmodule

// File: rtl/adc_rdc_frame_tx.sv
// Frame shifter.
// Holds the data bytes plus the checksum byte and steps a bit pointer on
// qualified serial rising edges, MSB first. The pointer wraps after the
// last bit for repeated readout.
// Output select: 0 during the update window, the shifted bit once a frame has
// started, otherwise the ready level.
// Assumes: cksum_en is stable during a read.
module adc_rdc_frame_tx #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic              active,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cksum_en,
    input  logic              drdy_n,
    input  logic              busy,
    output logic              dout,
    output logic              dout_oe
);
    import adc_rdc_pkg::*;

    localparam int FRAME_W = DATA_W + 8;
    localparam int PW      = $clog2(FRAME_W);
    localparam logic [PW-1:0] LAST_FULL = PW'(FRAME_W - 1);
    localparam logic [PW-1:0] LAST_DATA = PW'(DATA_W - 1);

    logic [FRAME_W-1:0] frame;
    logic [PW-1:0]      bit_pos;
    logic [PW-1:0]      last_pos;
    logic               started;
    logic               dout_q;

    assign last_pos = cksum_en ? LAST_FULL : LAST_DATA;

    // Frame load, chip-select restart and serial shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame   <= '0;
            bit_pos <= '0;
            started <= 1'b0;
            dout_q  <= 1'b0;
        end else if (load) begin
            frame   <= {load_data, frame_cksum(load_data)};
            bit_pos <= '0;
            started <= 1'b0;
        end else if (cs_n) begin
            bit_pos <= '0;
            started <= 1'b0;
        end else if (sclk_rise && active) begin
            dout_q  <= frame[LAST_FULL - bit_pos];
            started <= 1'b1;
            bit_pos <= (bit_pos >= last_pos) ? '0 : bit_pos + 1'b1;
        end
    end

    // Output select: window forces low, then shifted bit, else ready level.
    always_comb begin
        if (busy)                  dout = 1'b0;
        else if (started && active) dout = dout_q;
        else                       dout = drdy_n;
    end

    assign dout_oe = !cs_n;

    AST_DESELECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (bit_pos == '0) && !started); // R10

endmodule

// File: rtl/adc_rdc_stop_det.sv
// Stop-command detector.
// Samples din on qualified serial falling edges and groups the bits into
// bytes from chip-select low. A byte equal to STOP_OPCODE clears active
// until reset.
module adc_rdc_stop_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk_fall,
    input  logic din,
    output logic active
);
    import adc_rdc_pkg::*;

    logic [2:0] bit_cnt;
    logic [6:0] shreg;

    // Byte assembly and opcode compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            active  <= 1'b1;
        end else if (cs_n) begin
            bit_cnt <= '0;
        end else if (sclk_fall) begin
            shreg   <= {shreg[5:0], din};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7 && {shreg, din} == STOP_OPCODE) begin
                active <= 1'b0;
            end
        end
    end

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active); // R11

endmodule

// File: rtl/adc_rdc_port.sv
// Top: continuous-read serial output port.
// Detects serial clock edges in the master-clock domain (inputs assumed
// synchronous to clk), then drives the update window, frame shifter and
// stop detector. Edges count only while chip select is low.
module adc_rdc_port #(
    parameter int DATA_W     = 24,
    parameter int UPD_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              mode_pulse,
    input  logic              cksum_en,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              drdy_n,
    output logic              dout,
    output logic              dout_oe,
    output logic              rdc_active
);
    logic              sclk_q;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              busy;
    logic              load;
    logic [DATA_W-1:0] data_q;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sclk_rise = sclk && !sclk_q && !cs_n;
    assign sclk_fall = !sclk && sclk_q && !cs_n;

    adc_rdc_upd_win #(.DATA_W(DATA_W), .UPD_CYCLES(UPD_CYCLES)) u_win (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .mode_pulse(mode_pulse), .sclk_fall(sclk_fall), .drdy_n(drdy_n),
        .busy(busy), .load(load), .data_q(data_q)
    );

    adc_rdc_frame_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
        .active(rdc_active), .load(load), .load_data(data_q),
        .cksum_en(cksum_en), .drdy_n(drdy_n), .busy(busy),
        .dout(dout), .dout_oe(dout_oe)
    );

    adc_rdc_stop_det u_stop (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall),
        .din(din), .active(rdc_active)
    );

    AST_OE_FOLLOWS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !dout_oe); // R1

endmodule

// File: tb/adc_rdc_port_test.sv
module adc_rdc_port_test;
    localparam int UPD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [23:0] res_data = '0;
    logic        mode_pulse = 1'b0;
    logic        cksum_en = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        drdy_n, dout, dout_oe, rdc_active;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    adc_rdc_port uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .mode_pulse(mode_pulse), .cksum_en(cksum_en), .cs_n(cs_n),
        .sclk(sclk), .din(din), .drdy_n(drdy_n), .dout(dout),
        .dout_oe(dout_oe), .rdc_active(rdc_active)
    );

    // vector: {pulse, cksum, data}
    localparam logic [25:0] VEC [0:5] = '{
        {1'b0, 1'b0, 24'hA5C3F0},
        {1'b1, 1'b0, 24'h000001},
        {1'b0, 1'b1, 24'h123456},
        {1'b1, 1'b1, 24'hFFFFFF},
        {1'b0, 1'b1, 24'h800000},
        {1'b1, 1'b0, 24'h7E81C3}
    };

    function automatic logic [7:0] exp_ck(input logic [23:0] d);
        return 8'(d[23:16] + d[15:8] + d[7:0] + 8'h9B);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic strobe(input logic [23:0] d);
        @(negedge clk); res_valid = 1'b1; res_data = d;
        @(negedge clk); res_valid = 1'b0;
    endtask

    task automatic sbit(input logic d, output logic b);
        @(negedge clk); sclk = 1'b1; din = d;
        @(negedge clk); b = dout; sclk = 1'b0;
        @(negedge clk); din = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] cmd, output logic [7:0] got);
        logic b;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            sbit(cmd[i], b);
            got = {got[6:0], b};
        end
    endtask

    task automatic read_n(input int n, output logic [31:0] got);
        logic b;
        got = '0;
        for (int i = 0; i < n; i++) begin
            sbit(1'b0, b);
            got = {got[30:0], b};
        end
    endtask

    task automatic reselect();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [7:0]  gb;
        logic        b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drdy", drdy_n, 1);
        chk("R1 active", rdc_active, 1);
        chk("R1 oe", dout_oe, 0);
        cs_n = 1'b0;
        @(negedge clk);
        chk("R1 dout follows", dout, 1);
        chk("R1 oe low select", dout_oe, 1);

        // Table walk: R2, R4, R5, R6, R8, R9
        for (int v = 0; v < 6; v++) begin
            logic [23:0] d;
            logic [31:0] exp;
            int          nb;
            d = VEC[v][23:0];
            mode_pulse = VEC[v][25];
            cksum_en = VEC[v][24];
            reselect();
            strobe(d);
            repeat (UPD - 1) @(negedge clk);
            chk("R2 still high", drdy_n, 1);
            @(negedge clk);
            chk("R2 falls", drdy_n, 0);
            chk("R4 dout low", dout, 0);
            nb = cksum_en ? 32 : 24;
            exp = cksum_en ? {d, exp_ck(d)} : {8'h0, d};
            read_n(nb, got);
            chk(cksum_en ? "R6 frame" : "R5 frame", got, exp);
            chk(mode_pulse ? "R9 drdy held" : "R8 drdy cleared", drdy_n, mode_pulse ? 0 : 1);
        end

        // R7: repeat after 24 bits (last vector left cksum off, pulse mode)
        read_n(8, got);
        chk("R7 repeat 24", got, 32'h7E);
        cksum_en = 1'b1;
        reselect();
        read_n(32, got);
        read_n(8, got);
        chk("R7 repeat 32", got, 32'h7E);

        // R10: deselect mid-frame restarts from MSB
        read_n(5, got);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        chk("R10 oe off", dout_oe, 0);
        cs_n = 1'b0;
        read_n(8, got);
        chk("R10 restart", got, 32'h7E);

        // R3: dout forced low during window
        cksum_en = 1'b0;
        reselect();
        strobe(24'h800000);
        repeat (UPD) @(negedge clk);
        sbit(1'b0, b);
        chk("R3 msb seen", b, 1);
        strobe(24'h800000);
        chk("R3 window low", dout, 0);
        chk("R3 drdy high", drdy_n, 1);
        repeat (UPD) @(negedge clk);
        chk("R4 after load", dout, 0);

        // R12: non-stop byte ignored
        reselect();
        sbyte(8'h12, gb);
        chk("R12 active", rdc_active, 1);
        chk("R12 stream", gb, 8'h80);

        // R11: stop byte
        reselect();
        sbyte(8'h11, gb);
        chk("R11 stopped", rdc_active, 0);
        read_n(4, got);
        chk("R11 no shift", got, {28'h0, {4{drdy_n}}});
        strobe(24'hFFFFFF);
        repeat (UPD) @(negedge clk);
        sbit(1'b0, b);
        chk("R11 dout follows drdy", b, drdy_n);
        chk("R11 sticky", rdc_active, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule